// File: doc/BRIEF.md
# LAN Coprocessor Control Window

This block is the host-side register window in front of a LAN coprocessor. A 32-bit host bus presents a 6-bit byte offset, an access size (byte or long word), a direction, write data and a one-cycle strobe. The block decodes the offset into one-clock command strobes and into two single-bit interrupt enables. It also returns two live status bits through reads. Each accepted cycle gets either an acknowledge or an error response.

A long-word write to the command offset raises a command strobe and presents the full 32-bit write data to the coprocessor. Other writes only signal an event: attention, interrupt clear, abort clear, and two debug triggers that idle high. For these, the write data has no effect. Every function except the command offset can also be reached by a byte access at its long-word offset plus 3. Byte data uses lane [7:0]. Unused offsets, misaligned accesses and a byte access to the command offset return an error and change nothing.

Top module: `lanctl_regwin`

## Requirements
- R1: After a synchronous active-high reset, both enables are 0. All strobes, ack and err are 0, and both trigger outputs are high.
- R2: A long-word write at offset 0x00 raises port_strobe for exactly one clock, in the cycle after acceptance, with port_data equal to the written word, and acks.
- R3: A byte access at offset 0x03 (the command word) is answered with err and raises no strobe.
- R4: A write at word offset 0x04, 0x0C or 0x1C (long) or at 0x07, 0x0F or 0x1F (byte) pulses chan_attn, irq_clear or abort_clear respectively for one clock, whatever the data.
- R5: A write at 0x10/0x13 sets coproc_irq_en, and a write at 0x14/0x17 sets abort_irq_en, each from data bit 0. A read there returns the enable in bit 0, with all other bits 0.
- R6: A read at 0x18/0x1B returns coproc_irq_in, and a read at 0x1C/0x1F returns abort_in, in bit 0. The value is the one sampled at the accepting edge (1 = asserted), and all other bits are 0.
- R7: A write at 0x38/0x3B drives trig_n[0] low for one clock, and a write at 0x3C/0x3F does the same for trig_n[1], whatever the data.
- R8: Accesses to word offsets 0x08 and 0x20 to 0x37 answer err, return rdata 0, and change no enable or strobe.
- R9: A long-word access with offset bits [1:0] not 00, or a byte access with offset bits [1:0] not 11, answers err with no side effect.
- R10: Each accepted cycle gives exactly one of ack or err in the next clock, with no response when bus_valid is low. Every strobe lasts one clock per accepted access.
- R11: Reads of write-only functions return 0 with ack and raise no strobe. A write to the read-only status offset 0x18 acks and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one access per high cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_long | input | 1 | 1 = long-word access, 0 = byte access |
| bus_offset | input | 6 | Byte offset within the window |
| bus_wdata | input | 32 | Write data (byte data on [7:0]) |
| coproc_irq_in | input | 1 | Live coprocessor interrupt level |
| abort_in | input | 1 | Live abort condition level |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access completed |
| bus_err | output | 1 | Access refused |
| port_strobe | output | 1 | Command strobe to the coprocessor |
| port_data | output | 32 | Command word, valid with port_strobe |
| chan_attn | output | 1 | Channel attention pulse |
| irq_clear | output | 1 | Interrupt clear pulse |
| abort_clear | output | 1 | Abort clear pulse |
| trig_n | output | 2 | Active-low debug trigger pulses |
| coproc_irq_en | output | 1 | Coprocessor interrupt enable |
| abort_irq_en | output | 1 | Abort interrupt enable |

## Verification
The responses, read data, strobes and trigger pulses are registered, so they appear in the single cycle after the accepting edge. The enables change at that same accepting edge. The bench drives each access on a falling edge and samples every result on the next falling edge. It then drops bus_valid and samples again one cycle later to confirm each pulse has ended. Status inputs are held steady across the accepting edge, so the expected read value is the one that was driven.

// File: rtl/lanctl_pkg.sv
package lanctl_pkg;

    localparam int OFS_W      = 6;
    localparam int NUM_TRIG   = 2;
    localparam int NUM_ENABLE = 2;

    typedef enum logic [3:0] {
        FN_NONE,
        FN_PORT,
        FN_ATTN,
        FN_ICLR,
        FN_COP_EN,
        FN_ABT_EN,
        FN_COP_STAT,
        FN_ABORT,
        FN_TRIG0,
        FN_TRIG1
    } func_e;

    typedef struct packed {
        logic  legal;
        func_e fn;
    } dec_t;

    // Function selection by word index; lane check depends on size.
    function automatic dec_t decode_access(logic is_long, logic [OFS_W-1:0] ofs);
        dec_t d;
        logic lane_ok;
        lane_ok = is_long ? (ofs[1:0] == 2'b00) : (ofs[1:0] == 2'b11);
        d.fn    = FN_NONE;
        case (ofs[OFS_W-1:2])
            4'h0: d.fn = FN_PORT;
            4'h1: d.fn = FN_ATTN;
            4'h3: d.fn = FN_ICLR;
            4'h4: d.fn = FN_COP_EN;
            4'h5: d.fn = FN_ABT_EN;
            4'h6: d.fn = FN_COP_STAT;
            4'h7: d.fn = FN_ABORT;
            4'hE: d.fn = FN_TRIG0;
            4'hF: d.fn = FN_TRIG1;
            default: d.fn = FN_NONE;
        endcase
        d.legal = lane_ok && (d.fn != FN_NONE) && !((d.fn == FN_PORT) && !is_long);
        return d;
    endfunction

endpackage

// File: rtl/lanctl_decode.sv
module lanctl_decode
    import lanctl_pkg::*;
(
    input  logic             is_long,
    input  logic [OFS_W-1:0] ofs,
    output dec_t             dec
);
    always_comb dec = decode_access(is_long, ofs);
endmodule

// File: rtl/lanctl_enables.sv
module lanctl_enables #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] wr_sel,
    input  logic         wbit,
    output logic [N-1:0] en
);
    for (genvar i = 0; i < N; i++) begin : g_en
        always_ff @(posedge clk) begin
            if (rst)            en[i] <= 1'b0;
            else if (wr_sel[i]) en[i] <= wbit;
        end
    end
endmodule

// File: rtl/lanctl_pulses.sv
module lanctl_pulses #(
    parameter int DATA_W = 32,
    parameter int NTRIG  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_port,
    input  logic [DATA_W-1:0] port_din,
    input  logic              fire_attn,
    input  logic              fire_iclr,
    input  logic              fire_aclr,
    input  logic [NTRIG-1:0]  fire_trig,
    output logic              port_q,
    output logic [DATA_W-1:0] port_dq,
    output logic              attn_q,
    output logic              iclr_q,
    output logic              aclr_q,
    output logic [NTRIG-1:0]  trig_nq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            port_q  <= 1'b0;
            port_dq <= '0;
            attn_q  <= 1'b0;
            iclr_q  <= 1'b0;
            aclr_q  <= 1'b0;
        end else begin
            port_q  <= fire_port;
            if (fire_port) port_dq <= port_din;
            attn_q  <= fire_attn;
            iclr_q  <= fire_iclr;
            aclr_q  <= fire_aclr;
        end
    end

    for (genvar t = 0; t < NTRIG; t++) begin : g_trig
        always_ff @(posedge clk) begin
            if (rst) trig_nq[t] <= 1'b1;
            else     trig_nq[t] <= ~fire_trig[t];
        end
    end
endmodule

// File: rtl/lanctl_regwin.sv
module lanctl_regwin
    import lanctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic                bus_long,
    input  logic [OFS_W-1:0]    bus_offset,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                coproc_irq_in,
    input  logic                abort_in,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_ack,
    output logic                bus_err,
    output logic                port_strobe,
    output logic [DATA_W-1:0]   port_data,
    output logic                chan_attn,
    output logic                irq_clear,
    output logic                abort_clear,
    output logic [NUM_TRIG-1:0] trig_n,
    output logic                coproc_irq_en,
    output logic                abort_irq_en
);
    dec_t                  dec;
    logic                  wr_go;
    logic                  rd_go;
    logic [NUM_ENABLE-1:0] en_sel;
    logic [NUM_ENABLE-1:0] en_val;
    logic [NUM_TRIG-1:0]   trig_fire;
    logic                  rd_bit;
    logic [DATA_W-1:0]     rd_word;

    lanctl_decode u_dec (
        .is_long (bus_long),
        .ofs     (bus_offset),
        .dec     (dec)
    );

    assign wr_go = bus_valid && bus_write && dec.legal;
    assign rd_go = bus_valid && !bus_write && dec.legal;

    assign en_sel[0] = wr_go && (dec.fn == FN_COP_EN);
    assign en_sel[1] = wr_go && (dec.fn == FN_ABT_EN);

    lanctl_enables #(.N(NUM_ENABLE)) u_en (
        .clk    (clk),
        .rst    (rst),
        .wr_sel (en_sel),
        .wbit   (bus_wdata[0]),
        .en     (en_val)
    );
    assign coproc_irq_en = en_val[0];
    assign abort_irq_en  = en_val[1];

    assign trig_fire[0] = wr_go && (dec.fn == FN_TRIG0);
    assign trig_fire[1] = wr_go && (dec.fn == FN_TRIG1);

    lanctl_pulses #(.DATA_W(DATA_W), .NTRIG(NUM_TRIG)) u_pulse (
        .clk       (clk),
        .rst       (rst),
        .fire_port (wr_go && (dec.fn == FN_PORT)),
        .port_din  (bus_wdata),
        .fire_attn (wr_go && (dec.fn == FN_ATTN)),
        .fire_iclr (wr_go && (dec.fn == FN_ICLR)),
        .fire_aclr (wr_go && (dec.fn == FN_ABORT)),
        .fire_trig (trig_fire),
        .port_q    (port_strobe),
        .port_dq   (port_data),
        .attn_q    (chan_attn),
        .iclr_q    (irq_clear),
        .aclr_q    (abort_clear),
        .trig_nq   (trig_n)
    );

    always_comb begin
        case (dec.fn)
            FN_COP_EN:   rd_bit = en_val[0];
            FN_ABT_EN:   rd_bit = en_val[1];
            FN_COP_STAT: rd_bit = coproc_irq_in;
            FN_ABORT:    rd_bit = abort_in;
            default:     rd_bit = 1'b0;
        endcase
        rd_word = {{(DATA_W-1){1'b0}}, rd_bit};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ack   <= 1'b0;
            bus_err   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack   <= bus_valid && dec.legal;
            bus_err   <= bus_valid && !dec.legal;
            bus_rdata <= rd_go ? rd_word : '0;
        end
    end
endmodule

// File: rtl/lanctl_regwin_chk.sv
module lanctl_regwin_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_valid,
    input logic       bus_write,
    input logic       bus_long,
    input logic [5:0] bus_offset,
    input logic       bus_ack,
    input logic       bus_err,
    input logic       port_strobe,
    input logic       chan_attn,
    input logic       irq_clear,
    input logic       abort_clear,
    input logic [1:0] trig_n,
    input logic       coproc_irq_en,
    input logic       abort_irq_en
);
    // R10
    ack_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_ack && bus_err));
    // R10
    resp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid |=> (bus_ack || bus_err));
    // R10
    no_resp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> (!bus_ack && !bus_err && !port_strobe && !chan_attn
                        && !irq_clear && !abort_clear && (trig_n == 2'b11)));
    // R3
    port_byte_err_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_long && bus_offset[5:2] == 4'h0) |=> (bus_err && !port_strobe));
    // R9
    misalign_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_long && bus_offset[1:0] != 2'b00) |=> bus_err);
    // R7
    trig_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~trig_n));
    // R5
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && bus_write) |=> ($stable(coproc_irq_en) && $stable(abort_irq_en)));
    // R2
    port_acked_chk: assert property (@(posedge clk) disable iff (rst)
        port_strobe |-> bus_ack);
endmodule

bind lanctl_regwin lanctl_regwin_chk chk_i (.*);

// File: tb/lanctl_regwin_test.sv
module lanctl_regwin_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_long = 1'b1;
    logic [5:0]  bus_offset = '0;
    logic [31:0] bus_wdata = '0;
    logic        coproc_irq_in = 1'b0, abort_in = 1'b0;
    logic [31:0] bus_rdata, port_data;
    logic        bus_ack, bus_err, port_strobe, chan_attn, irq_clear, abort_clear;
    logic [1:0]  trig_n;
    logic        coproc_irq_en, abort_irq_en;

    int errors = 0, checks = 0;
    bit done = 0;
    bit m_cen = 0, m_aen = 0;

    always #2.5 clk = ~clk;

    lanctl_regwin uut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit m_legal(bit lng, logic [5:0] o);
        if (lng && o[1:0] != 2'b00) return 0;
        if (!lng && o[1:0] != 2'b11) return 0;
        case (o[5:2])
            4'h0: return lng;
            4'h1, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hE, 4'hF: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic string err_tag(bit lng, logic [5:0] o);
        if ((lng && o[1:0] != 0) || (!lng && o[1:0] != 3)) return "R9";
        if (o[5:2] == 0) return "R3";
        return "R8";
    endfunction

    function automatic logic [31:0] m_rdata(bit wr, bit lng, logic [5:0] o, bit ci, bit ab);
        if (wr || !m_legal(lng, o)) return 0;
        case (o[5:2])
            4'h4: return {31'd0, m_cen};
            4'h5: return {31'd0, m_aen};
            4'h6: return {31'd0, ci};
            4'h7: return {31'd0, ab};
            default: return 0;
        endcase
    endfunction

    task automatic access(bit wr, bit lng, logic [5:0] o, logic [31:0] d, bit ci, bit ab);
        bit lg, w;
        logic [3:0] ix;
        logic [31:0] exp_rd;
        lg = m_legal(lng, o);
        w  = wr && lg;
        ix = o[5:2];
        exp_rd = m_rdata(wr, lng, o, ci, ab);
        bus_valid = 1; bus_write = wr; bus_long = lng; bus_offset = o; bus_wdata = d;
        coproc_irq_in = ci; abort_in = ab;
        if (w && ix == 4'h4) m_cen = d[0];
        if (w && ix == 4'h5) m_aen = d[0];
        @(posedge clk); @(negedge clk);
        bus_valid = 0;
        chk("R10 ack", bus_ack, lg);
        chk(lg ? "R10 err" : err_tag(lng, o), bus_err, !lg);
        chk(ix == 6 || ix == 7 ? "R6 rdata" : (lg ? "R5/R11 rdata" : "R8 rdata"), bus_rdata, exp_rd);
        chk("R2 strobe", port_strobe, w && ix == 0);
        if (w && ix == 0) chk("R2 data", port_data, d);
        chk("R4 attn", chan_attn, w && ix == 1);
        chk("R4 iclr", irq_clear, w && ix == 3);
        chk("R4 aclr", abort_clear, w && ix == 7);
        chk("R7 trig", trig_n, {~(w && ix == 15), ~(w && ix == 14)});
        chk("R5 cen", coproc_irq_en, m_cen);
        chk("R5 aen", abort_irq_en, m_aen);
        @(posedge clk); @(negedge clk);
        chk("R10 pulse end", {port_strobe, chan_attn, irq_clear, abort_clear, bus_ack, bus_err}, 0);
        chk("R10 trig end", trig_n, 2'b11);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 en", {coproc_irq_en, abort_irq_en}, 0);
        chk("R1 out", {port_strobe, chan_attn, irq_clear, abort_clear, bus_ack, bus_err}, 0);
        chk("R1 trig", trig_n, 2'b11);
        // directed corner cases
        access(1, 1, 6'h00, 32'hDEAD_BEEF, 0, 0); // R2
        access(1, 0, 6'h03, 32'h0000_0011, 0, 0); // R3
        access(1, 1, 6'h04, 32'h0, 0, 0);         // R4
        access(1, 0, 6'h0F, 32'hFF, 0, 0);        // R4
        access(1, 0, 6'h1F, 32'h0, 0, 0);         // R4
        access(1, 1, 6'h10, 32'hFFFF_FFFF, 0, 0); // R5
        access(0, 0, 6'h13, 32'h0, 0, 0);         // R5
        access(1, 0, 6'h17, 32'h1, 0, 0);         // R5
        access(0, 1, 6'h18, 32'h0, 1, 0);         // R6
        access(0, 0, 6'h1F, 32'h0, 0, 1);         // R6
        access(1, 1, 6'h38, 32'h0, 0, 0);         // R7
        access(1, 0, 6'h3F, 32'h0, 0, 0);         // R7
        access(1, 1, 6'h08, 32'h1, 0, 0);         // R8
        access(1, 1, 6'h24, 32'h1, 0, 0);         // R8
        access(1, 1, 6'h12, 32'h0, 0, 0);         // R9
        access(1, 0, 6'h10, 32'h0, 0, 0);         // R9
        access(0, 1, 6'h04, 32'h0, 0, 0);         // R11
        access(1, 1, 6'h18, 32'h1, 1, 1);         // R11
        access(0, 1, 6'h00, 32'h0, 0, 0);         // R11
        // constrained random
        for (int i = 0; i < 600; i++) begin
            bit lng;
            logic [5:0] o;
            lng = $urandom_range(0, 1);
            o = 6'($urandom_range(0, 63));
            if ($urandom_range(0, 9) < 8) o[1:0] = lng ? 2'b00 : 2'b11;
            access($urandom_range(0, 1), lng, o, $urandom, $urandom_range(0, 1), $urandom_range(0, 1));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule